// File: doc/BRIEF.md
# Real-Time Clock Counter with Alarm Compare

This block is a real-time-clock core with a word-addressed 32-bit register interface. A programmable prescaler turns the slow oscillator clock into sub-second ticks, and a 32-bit counter advances by one on each tick. Software can read the counter, write the counter, and change the divider at any time.

Two alarm compare registers watch the counter. When the counter advances onto an alarm value and that alarm is enabled, a pending flag sets. A periodic-tick pending flag also sets on every advance. The status word holds pending bits, which are cleared by writing one to them, next to enable bits, which take the value written to them. The single interrupt and wake-up output is active whenever any pending bit is set together with its enable bit.

A clock-select register gates counting: only one code lets the oscillator drive the counter. A scratch word and a sleep-control word are plain storage that keep their value while the counter runs.

Top module: `rtc_alarm_core`

## Requirements
- R1: After reset every register reads zero and the interrupt output is low. Any byte address not listed in R2 or R7 reads zero, and a write to it changes no register.
- R2: The storage registers sit at these byte addresses and read back what was written: alarm0 at 0x04, alarm1 at 0x18, scratch at 0x40 (all 32 bits), sleep control at 0x14 (32 bits), divider at 0x0C (low 16 bits, upper bits read zero), clock select at 0x1C (low 8 bits, upper bits read zero). The counter is read and written at 0x00.
- R3: While clock select holds 0x03, the counter advances once every 2×(DIV+1) clocks, where DIV is the divider value. The first advance comes 2×(DIV+1) clocks after the clock-select write that started counting.
- R4: While clock select holds any value other than 0x03, the counter does not change unless software writes it.
- R5: A counter write loads the written value and restarts the prescaler, so the next advance follows a full 2×(DIV+1) clocks after the write.
- R6: The counter wraps from 0xFFFFFFFF to 0x00000000 on an advance.
- R7: The status word is at 0x08 with bit 0 alarm0 pending, bit 1 tick pending, bit 2 alarm0 enable, bit 3 tick enable, bit 4 alarm1 pending and bit 6 alarm1 enable; the other bits read zero. A status write loads bits 2, 3 and 6 directly.
- R8: Writing 1 to a pending bit clears it; writing 0 to a pending bit leaves it unchanged.
- R9: The tick pending bit sets on every counter advance, whether or not the tick enable is set.
- R10: An alarm pending bit sets in the same cycle the counter advances onto that alarm's value, only if that alarm's enable bit is set at that time.
- R11: The interrupt output is high exactly when some pending bit and its own enable bit are both set.
- R12: The scratch register is never modified by counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; also clocks the register interface |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 8 | Byte address of the register accessed |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_wake_o | output | 1 | Interrupt and wake-up request |

## Verification
On every cycle the assertions check that the counter moves by at most one step unless written, that it stays still while clock select is off, that an alarm pending bit only rises when the counter lands on the stored alarm value with the enable set, that the scratch word only changes on its own write, and that the interrupt agrees with the status word whenever that word is addressed. The exact tick period for each divider value, the wrap, the first-advance latency after a start or a counter load, and the write-one-to-clear behaviour are only shown by the bench's scenarios, which sweep small divider values and compute the expected counter arithmetically.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int unsigned WORD_W    = 32;
    localparam int unsigned BADDR_W   = 8;
    localparam int unsigned NUM_ALARM = 2;

    // Byte offsets of the register words
    localparam logic [BADDR_W-1:0] OFS_COUNT   = 8'h00;
    localparam logic [BADDR_W-1:0] OFS_ALARM0  = 8'h04;
    localparam logic [BADDR_W-1:0] OFS_STATUS  = 8'h08;
    localparam logic [BADDR_W-1:0] OFS_DIV     = 8'h0C;
    localparam logic [BADDR_W-1:0] OFS_SLEEP   = 8'h14;
    localparam logic [BADDR_W-1:0] OFS_ALARM1  = 8'h18;
    localparam logic [BADDR_W-1:0] OFS_CSEL    = 8'h1C;
    localparam logic [BADDR_W-1:0] OFS_SCRATCH = 8'h40;

    // Clock-select code that lets the oscillator drive the counter
    localparam logic [7:0] CSEL_RUN = 8'h03;

    // Status word bit positions
    localparam int unsigned SB_AL0_PEND  = 0;
    localparam int unsigned SB_TICK_PEND = 1;
    localparam int unsigned SB_AL0_EN    = 2;
    localparam int unsigned SB_TICK_EN   = 3;
    localparam int unsigned SB_AL1_PEND  = 4;
    localparam int unsigned SB_AL1_EN    = 6;

    typedef enum logic [3:0] {
        RS_NONE,
        RS_COUNT,
        RS_ALARM0,
        RS_STATUS,
        RS_DIV,
        RS_SLEEP,
        RS_ALARM1,
        RS_CSEL,
        RS_SCRATCH
    } reg_sel_e;

    typedef struct packed {
        logic al1_en;
        logic al1_pend;
        logic tick_en;
        logic al0_en;
        logic tick_pend;
        logic al0_pend;
    } stat_t;

    typedef struct packed {
        logic                wr;
        reg_sel_e            sel;
        logic [WORD_W-1:0]   data;
    } reg_req_t;

    function automatic reg_sel_e decode_addr(input logic [BADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            OFS_COUNT:   s = RS_COUNT;
            OFS_ALARM0:  s = RS_ALARM0;
            OFS_STATUS:  s = RS_STATUS;
            OFS_DIV:     s = RS_DIV;
            OFS_SLEEP:   s = RS_SLEEP;
            OFS_ALARM1:  s = RS_ALARM1;
            OFS_CSEL:    s = RS_CSEL;
            OFS_SCRATCH: s = RS_SCRATCH;
            default:     s = RS_NONE;
        endcase
        return s;
    endfunction

    function automatic reg_sel_e alarm_sel(input int unsigned idx);
        return (idx == 0) ? RS_ALARM0 : RS_ALARM1;
    endfunction

    function automatic logic [WORD_W-1:0] stat_to_word(input stat_t s);
        logic [WORD_W-1:0] w;
        w               = '0;
        w[SB_AL0_PEND]  = s.al0_pend;
        w[SB_TICK_PEND] = s.tick_pend;
        w[SB_AL0_EN]    = s.al0_en;
        w[SB_TICK_EN]   = s.tick_en;
        w[SB_AL1_PEND]  = s.al1_pend;
        w[SB_AL1_EN]    = s.al1_en;
        return w;
    endfunction

    function automatic logic stat_irq(input stat_t s);
        return (s.al0_pend & s.al0_en) | (s.tick_pend & s.tick_en) |
               (s.al1_pend & s.al1_en);
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int unsigned PRE_W = DIV_W + 1;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] last_phase;

    // one tick spans 2*(div+1) clocks: phases 0 .. 2*div+1
    assign last_phase = {div, 1'b1};
    assign tick       = run && (pre_q == last_phase);

    always_ff @(posedge clk) begin
        if (rst || !run || restart) begin
            pre_q <= '0;
        end else if (tick) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_adv,
    output logic             adv
);
    // a software load takes priority over a tick in the same cycle
    assign adv     = tick && !load;
    assign cnt_adv = cnt_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (adv) begin
            cnt_q <= cnt_adv;
        end
    end
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic             adv,
    input  logic [CNT_W-1:0] cnt_adv,
    output logic [CNT_W-1:0] value_q,
    output logic             hit
);
    // compare against the value the counter is about to take
    assign hit = adv && (cnt_adv == value_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            value_q <= '0;
        end else if (wr) begin
            value_q <= wdata;
        end
    end
endmodule

// File: rtl/rtc_status.sv
module rtc_status
    import rtc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr,
    input  logic [WORD_W-1:0]    wdata,
    input  logic                 tick_evt,
    input  logic [NUM_ALARM-1:0] alarm_hit,
    output stat_t                stat_q,
    output logic                 irq
);
    stat_t stat_d;
    logic  clr_al0, clr_tick, clr_al1;

    assign clr_al0  = wr && wdata[SB_AL0_PEND];
    assign clr_tick = wr && wdata[SB_TICK_PEND];
    assign clr_al1  = wr && wdata[SB_AL1_PEND];

    always_comb begin
        stat_d = stat_q;
        // enables follow the written value
        if (wr) begin
            stat_d.al0_en  = wdata[SB_AL0_EN];
            stat_d.tick_en = wdata[SB_TICK_EN];
            stat_d.al1_en  = wdata[SB_AL1_EN];
        end
        // pending: write-one-to-clear, a new event wins over a clear
        stat_d.al0_pend  = (stat_q.al0_pend  && !clr_al0)  ||
                           (alarm_hit[0] && stat_q.al0_en);
        stat_d.tick_pend = (stat_q.tick_pend && !clr_tick) || tick_evt;
        stat_d.al1_pend  = (stat_q.al1_pend  && !clr_al1)  ||
                           (alarm_hit[1] && stat_q.al1_en);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
        end else begin
            stat_q <= stat_d;
        end
    end

    assign irq = stat_irq(stat_q);
endmodule

// File: rtl/rtc_alarm_core.sv
module rtc_alarm_core
    import rtc_pkg::*;
#(
    parameter int unsigned DIV_W  = 16,
    parameter int unsigned CSEL_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [BADDR_W-1:0] bus_addr,
    input  logic               bus_wr,
    input  logic [WORD_W-1:0]  bus_wdata,
    output logic [WORD_W-1:0]  bus_rdata,
    output logic               irq_wake_o
);
    reg_req_t req;

    logic [DIV_W-1:0]  div_q;
    logic [CSEL_W-1:0] csel_q;
    logic [WORD_W-1:0] sleep_q;
    logic [WORD_W-1:0] scratch_q;

    logic              run;
    logic              tick;
    logic              cnt_wr;
    logic              div_wr;
    logic              scr_wr;
    logic              adv;
    logic [WORD_W-1:0] cnt_q;
    logic [WORD_W-1:0] cnt_adv;

    logic [NUM_ALARM-1:0]             alarm_hit;
    logic [NUM_ALARM-1:0][WORD_W-1:0] alarm_q;
    stat_t                            stat_q;

    assign req.wr   = bus_wr;
    assign req.sel  = decode_addr(bus_addr);
    assign req.data = bus_wdata;

    assign cnt_wr = req.wr && (req.sel == RS_COUNT);
    assign div_wr = req.wr && (req.sel == RS_DIV);
    assign scr_wr = req.wr && (req.sel == RS_SCRATCH);
    assign run    = (csel_q == CSEL_W'(CSEL_RUN));

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q     <= '0;
            csel_q    <= '0;
            sleep_q   <= '0;
            scratch_q <= '0;
        end else if (req.wr) begin
            case (req.sel)
                RS_DIV:     div_q     <= req.data[DIV_W-1:0];
                RS_CSEL:    csel_q    <= req.data[CSEL_W-1:0];
                RS_SLEEP:   sleep_q   <= req.data;
                RS_SCRATCH: scratch_q <= req.data;
                default:    ;
            endcase
        end
    end

    rtc_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .restart (cnt_wr || div_wr),
        .div     (div_q),
        .tick    (tick)
    );

    rtc_counter #(.CNT_W(WORD_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .load     (cnt_wr),
        .load_val (req.data),
        .cnt_q    (cnt_q),
        .cnt_adv  (cnt_adv),
        .adv      (adv)
    );

    for (genvar gi = 0; gi < NUM_ALARM; gi++) begin : g_alarm
        rtc_alarm_cmp #(.CNT_W(WORD_W)) u_cmp (
            .clk     (clk),
            .rst     (rst),
            .wr      (req.wr && (req.sel == alarm_sel(gi))),
            .wdata   (req.data),
            .adv     (adv),
            .cnt_adv (cnt_adv),
            .value_q (alarm_q[gi]),
            .hit     (alarm_hit[gi])
        );
    end

    rtc_status u_stat (
        .clk       (clk),
        .rst       (rst),
        .wr        (req.wr && (req.sel == RS_STATUS)),
        .wdata     (req.data),
        .tick_evt  (adv),
        .alarm_hit (alarm_hit),
        .stat_q    (stat_q),
        .irq       (irq_wake_o)
    );

    always_comb begin
        case (req.sel)
            RS_COUNT:   bus_rdata = cnt_q;
            RS_ALARM0:  bus_rdata = alarm_q[0];
            RS_ALARM1:  bus_rdata = alarm_q[1];
            RS_STATUS:  bus_rdata = stat_to_word(stat_q);
            RS_DIV:     bus_rdata = WORD_W'(div_q);
            RS_SLEEP:   bus_rdata = sleep_q;
            RS_CSEL:    bus_rdata = WORD_W'(csel_q);
            RS_SCRATCH: bus_rdata = scratch_q;
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/rtc_alarm_core_chk.sv
module rtc_alarm_core_chk
    import rtc_pkg::*;
#(
    parameter int unsigned CSEL_W = 8
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [BADDR_W-1:0]               bus_addr,
    input  logic [WORD_W-1:0]                bus_rdata,
    input  logic                             irq_wake_o,
    input  logic [WORD_W-1:0]                cnt_q,
    input  logic                             cnt_wr,
    input  logic                             scr_wr,
    input  logic [CSEL_W-1:0]                csel_q,
    input  logic [WORD_W-1:0]                scratch_q,
    input  logic [NUM_ALARM-1:0][WORD_W-1:0] alarm_q,
    input  stat_t                            stat_q
);
    assert_single_step_R3: assert property (@(posedge clk) disable iff (rst)
        !$past(cnt_wr) |-> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1));

    assert_halt_when_off_R4: assert property (@(posedge clk) disable iff (rst)
        ($past(csel_q) != CSEL_W'(CSEL_RUN)) && !$past(cnt_wr) |-> $stable(cnt_q));

    assert_alarm0_on_match_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_q.al0_pend) |-> $past(stat_q.al0_en) && (cnt_q == $past(alarm_q[0])));

    assert_alarm1_on_match_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_q.al1_pend) |-> $past(stat_q.al1_en) && (cnt_q == $past(alarm_q[1])));

    assert_scratch_hold_R12: assert property (@(posedge clk) disable iff (rst)
        !$past(scr_wr) |-> $stable(scratch_q));

    assert_irq_vs_status_R11: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == OFS_STATUS) |->
        irq_wake_o == ((bus_rdata[SB_AL0_PEND] & bus_rdata[SB_AL0_EN]) |
                       (bus_rdata[SB_TICK_PEND] & bus_rdata[SB_TICK_EN]) |
                       (bus_rdata[SB_AL1_PEND] & bus_rdata[SB_AL1_EN])));
endmodule

bind rtc_alarm_core rtc_alarm_core_chk #(.CSEL_W(CSEL_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .irq_wake_o (irq_wake_o),
    .cnt_q      (cnt_q),
    .cnt_wr     (cnt_wr),
    .scr_wr     (scr_wr),
    .csel_q     (csel_q),
    .scratch_q  (scratch_q),
    .alarm_q    (alarm_q),
    .stat_q     (stat_q)
);

// File: tb/test_rtc_alarm_core.sv
module test_rtc_alarm_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        irq_wake_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    localparam logic [7:0] A_CNT = 8'h00, A_AL0 = 8'h04, A_STAT = 8'h08,
                           A_DIV = 8'h0C, A_SLP = 8'h14, A_AL1 = 8'h18,
                           A_SEL = 8'h1C, A_SCR = 8'h40;

    always #10 clk = ~clk;

    rtc_alarm_core i_rtc_alarm_core (
        .clk        (clk),
        .rst        (rst),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .irq_wake_o (irq_wake_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic wait_cyc(input int m);
        repeat (m) @(negedge clk);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        wait_cyc(3);
        rst = 1'b0;
        wait_cyc(1);

        // R1: everything zero after reset, including reserved offsets
        for (int a = 0; a <= 8'h44; a += 4) begin
            rd_chk("R1 reset read", 8'(a), 32'h0);
        end
        chk("R1 reset irq", {31'h0, irq_wake_o}, 32'h0);

        // R2: register storage and widths
        wr(A_AL0, 32'hA5A5_1234);
        wr(A_AL1, 32'h5A5A_8765);
        wr(A_DIV, 32'hFFFF_ABCD);
        wr(A_SLP, 32'h1234_5678);
        wr(A_SEL, 32'h0000_01FF);
        wr(A_SCR, 32'hDEAD_BEEF);
        rd_chk("R2 alarm0", A_AL0, 32'hA5A5_1234);
        rd_chk("R2 alarm1", A_AL1, 32'h5A5A_8765);
        rd_chk("R2 divider", A_DIV, 32'h0000_ABCD);
        rd_chk("R2 sleep", A_SLP, 32'h1234_5678);
        rd_chk("R2 clksel", A_SEL, 32'h0000_00FF);
        rd_chk("R2 scratch", A_SCR, 32'hDEAD_BEEF);
        rd_chk("R4 counter idle under code 0xFF", A_CNT, 32'h0);

        // R1: reserved writes change nothing
        wr(8'h10, 32'hFFFF_FFFF);
        wr(8'h20, 32'hFFFF_FFFF);
        wr(8'h3C, 32'hFFFF_FFFF);
        wr(8'h44, 32'hFFFF_FFFF);
        wr(8'h06, 32'hFFFF_FFFF);
        rd_chk("R1 reserved read 0x10", 8'h10, 32'h0);
        rd_chk("R1 reserved read 0x06", 8'h06, 32'h0);
        rd_chk("R1 reserved write kept alarm0", A_AL0, 32'hA5A5_1234);
        rd_chk("R1 reserved write kept scratch", A_SCR, 32'hDEAD_BEEF);
        rd_chk("R1 reserved write kept sleep", A_SLP, 32'h1234_5678);
        rd_chk("R1 reserved write kept counter", A_CNT, 32'h0);
        rd_chk("R1 reserved write kept status", A_STAT, 32'h0);

        // R7: enable bits load directly, other bits read zero
        wr(A_STAT, 32'hFFFF_FFFF);
        rd_chk("R7 enables set", A_STAT, 32'h0000_004C);
        wr(A_STAT, 32'h0000_0013);
        rd_chk("R7 enables cleared", A_STAT, 32'h0);

        // R3: tick period sweep over small divider values
        for (int d = 0; d < 5; d++) begin
            int p;
            p = 2 * (d + 1);
            wr(A_SEL, 32'h0);
            wr(A_DIV, 32'(d));
            wr(A_CNT, 32'h0);
            wr(A_SEL, 32'h3);
            for (int m = 0; m <= 3 * p; m++) begin
                rd_chk($sformatf("R3 div=%0d m=%0d", d, m), A_CNT, 32'(m / p));
                wait_cyc(1);
            end
        end

        // R4: reserved clock-select codes hold the counter
        wr(A_SEL, 32'h0000_0007);
        rd(A_CNT, v);
        wait_cyc(20);
        rd_chk("R4 hold under code 0x07", A_CNT, v);
        wr(A_SEL, 32'h0000_0002);
        wait_cyc(20);
        rd_chk("R4 hold under code 0x02", A_CNT, v);

        // R5 + R6: counter load mid-run and wrap
        wr(A_SEL, 32'h3);
        wr(A_DIV, 32'h1);
        wait_cyc(3);
        wr(A_CNT, 32'hFFFF_FFFE);
        for (int m = 0; m <= 12; m++) begin
            rd_chk($sformatf("R5 R6 load/wrap m=%0d", m), A_CNT, 32'hFFFF_FFFE + 32'(m / 4));
            wait_cyc(1);
        end
        rd_chk("R12 scratch after counting", A_SCR, 32'hDEAD_BEEF);

        // R9: tick pending sets on advance regardless of enable
        wr(A_SEL, 32'h0);
        wr(A_DIV, 32'h0);
        wr(A_STAT, 32'h13);
        rd_chk("R8 all pending cleared", A_STAT, 32'h0);
        wr(A_CNT, 32'h0);
        wr(A_SEL, 32'h3);
        wait_cyc(1);
        rd_chk("R9 no tick pending before advance", A_STAT, 32'h0);
        wait_cyc(1);
        rd_chk("R9 tick pending after advance", A_STAT, 32'h2);
        chk("R11 irq low with tick disabled", {31'h0, irq_wake_o}, 32'h0);
        wr(A_STAT, 32'h08);
        rd(A_STAT, v);
        chk("R8 zero write keeps tick pending", v & 32'h2, 32'h2);
        chk("R11 irq high with tick enabled", {31'h0, irq_wake_o}, 32'h1);
        wr(A_SEL, 32'h0);
        wr(A_STAT, 32'h0A);
        rd_chk("R8 tick pending cleared by one", A_STAT, 32'h08);
        chk("R11 irq low after clear", {31'h0, irq_wake_o}, 32'h0);

        // R10: alarm0 enabled, alarm1 disabled, both at 8
        wr(A_STAT, 32'h13);
        wr(A_AL0, 32'h8);
        wr(A_AL1, 32'h8);
        wr(A_CNT, 32'h5);
        wr(A_STAT, 32'h04);
        wr(A_SEL, 32'h3);
        wait_cyc(5);
        rd_chk("R10 count before match", A_CNT, 32'h7);
        rd(A_STAT, v);
        chk("R10 alarm0 not yet pending", v & 32'h11, 32'h0);
        chk("R11 irq low before match", {31'h0, irq_wake_o}, 32'h0);
        wait_cyc(1);
        rd_chk("R10 count at match", A_CNT, 32'h8);
        rd(A_STAT, v);
        chk("R10 alarm0 pending, alarm1 disabled", v & 32'h11, 32'h01);
        chk("R11 irq high on alarm0", {31'h0, irq_wake_o}, 32'h1);
        wr(A_SEL, 32'h0);
        wr(A_STAT, 32'h04);
        rd(A_STAT, v);
        chk("R8 zero write keeps alarm0 pending", v & 32'h1, 32'h1);
        wr(A_STAT, 32'h05);
        rd(A_STAT, v);
        chk("R8 alarm0 cleared by one", v & 32'h5, 32'h4);
        chk("R11 irq low after alarm0 clear", {31'h0, irq_wake_o}, 32'h0);

        // R10: alarm1 enabled, alarm0 disabled
        wr(A_STAT, 32'h53);
        wr(A_CNT, 32'h6);
        wr(A_SEL, 32'h3);
        wait_cyc(3);
        rd(A_STAT, v);
        chk("R10 alarm1 not yet pending", v & 32'h11, 32'h0);
        wait_cyc(1);
        rd_chk("R10 count at alarm1 match", A_CNT, 32'h8);
        rd(A_STAT, v);
        chk("R10 alarm1 pending, alarm0 disabled", v & 32'h11, 32'h10);
        chk("R11 irq high on alarm1", {31'h0, irq_wake_o}, 32'h1);
        wr(A_SEL, 32'h0);
        rd_chk("R12 scratch at end", A_SCR, 32'hDEAD_BEEF);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule